// File: doc/BRIEF.md
# Vehicle Dashboard Clock Timekeeper

This block keeps the time of day for a small dashboard clock. A one-cycle pulse arriving once per second drives an internal seconds count. The seconds count carries into minutes, and minutes carry into hours. The block presents the time as four BCD digits and shows it in either 12-hour form with morning and afternoon indicators or in 24-hour form. Two debounced push-switch levels set the time: one steps the hours and one steps the minutes. The switches act only while the ignition input is active.

Holding both switches with ignition active puts the block in a test state, in which it requests every display segment on. When both switches are released, the block runs a restart step. The restart step always swaps the 12/24-hour format. It also returns the time to 1:00, unless the DATA line is held low during that step. In that case the time of day is kept and shown in the new format.

Internally the hour is held in 24-hour binary (0 to 23). The display side converts it to the selected form, so a format swap never changes the actual time. The state machine has three states:

- RUN: normal timekeeping and setting.
- TEST: the all-segments request. It is entered from RUN when ignition and both switches are active.
- RESTART: lasts one cycle. It is entered from TEST when both switches are released, and always returns to RUN.

Top module: `autoclk_ctrl`

## Requirements
- R1: After power-on reset the display shows 01:00 with `am`=1, `pm`=0, `fmt24`=0 and `all_seg`=0.
- R2: In 12-hour form the hour digits show 12, 1, 2 … 11. Internal hours 0–11 give `am`=1 and hours 12–23 give `pm`=1. In 24-hour form the digits show 00–23 and both indicators are 0. The outputs `am` and `pm` are never both 1.
- R3: Every 60th `tick_1hz` pulse in RUN, with no setting active, advances the minutes by one. Minute 59 carries into the hour, and 23:59 wraps to 00:00 (shown as 12:00 AM in 12-hour form).
- R4: With `ign_on`=1, `sw_hr`=1 and `sw_min`=0, the hour advances once in the cycle the press is first seen. After that it advances once for every tick while the press is held. The hour wraps 23 to 0. The seconds count is cleared and does not run while a switch is held.
- R5: `sw_min` alone, with `ign_on`=1, steps the minutes in the same way. The minutes wrap 59 to 00 without changing the hour.
- R6: With `ign_on`=0, neither switch changes the displayed time; only ticks advance it.
- R7: In RUN, `ign_on`=1 with both switches at 1 sets `all_seg` from the next cycle. `all_seg` stays 1 until both switches read 0.
- R8: The cycle after `all_seg` falls (the RESTART cycle), `fmt24` inverts at the following edge. If `data_lvl`=1 in that cycle, the time and seconds return to 01:00:00.
- R9: If `data_lvl`=0 in the RESTART cycle, the hours and minutes are kept, and the same time of day is shown in the new format.
- R10: Both switches pressed with `ign_on`=0 neither raises `all_seg` nor changes the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| sw_hr | input | 1 | Debounced hour-set switch, 1 = pressed |
| sw_min | input | 1 | Debounced minute-set switch, 1 = pressed |
| ign_on | input | 1 | Ignition active, enables the switches |
| data_lvl | input | 1 | DATA line level; 0 during RESTART keeps the time |
| hr_tens | output | 4 | Hour tens digit, BCD |
| hr_ones | output | 4 | Hour ones digit, BCD |
| min_tens | output | 4 | Minute tens digit, BCD |
| min_ones | output | 4 | Minute ones digit, BCD |
| am | output | 1 | Morning indicator (12-hour form only) |
| pm | output | 1 | Afternoon indicator (12-hour form only) |
| fmt24 | output | 1 | 1 = 24-hour form |
| all_seg | output | 1 | Request all display segments on |

## Verification
Directed steps drive the clock through several distinct cases:

- A run of 60 ticks separates the seconds carry from a bare minute step.
- A press held across several ticks shows the difference between the first-press step and the tick-rate repeat.
- A minute sweep through 59 to 00 confirms that no carry reaches the hour.

Held presses with ignition off cover the gating cases. Two test-state exits, one with DATA low and one with DATA high, separate the format swap from the time reset.

Random switch, ignition, tick and DATA patterns from a fixed seed then mix overlapping presses, release orderings and format swaps. Each cycle is compared against a bench model built from the requirements.

// File: rtl/autoclk_pkg.sv
package autoclk_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_TEST,
        ST_RESTART
    } clk_state_e;

endpackage

// File: rtl/autoclk_time.sv
module autoclk_time #(
    parameter int SEC_N    = 60,
    parameter int MIN_N    = 60,
    parameter int HR_N     = 24,
    parameter int START_HR = 1,
    localparam int SW = $clog2(SEC_N),
    localparam int MW = $clog2(MIN_N),
    localparam int HW = $clog2(HR_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          inc_hr,
    input  logic          inc_min,
    input  logic          adv_tick,
    output logic [HW-1:0] hr,
    output logic [MW-1:0] mins
);

    localparam logic [SW-1:0] SEC_LAST = SW'(SEC_N - 1);
    localparam logic [MW-1:0] MIN_LAST = MW'(MIN_N - 1);
    localparam logic [HW-1:0] HR_LAST  = HW'(HR_N - 1);
    localparam logic [HW-1:0] HR_INIT  = HW'(START_HR);

    logic [SW-1:0] sec;

    function automatic logic [HW-1:0] hr_step(input logic [HW-1:0] h);
        return (h == HR_LAST) ? '0 : h + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec  <= '0;
            mins <= '0;
            hr   <= HR_INIT;
        end else if (restart) begin
            sec  <= '0;
            mins <= '0;
            hr   <= HR_INIT;
        end else if (inc_hr || inc_min) begin
            sec <= '0;
            if (inc_hr) begin
                hr <= hr_step(hr);
            end
            if (inc_min) begin
                mins <= (mins == MIN_LAST) ? '0 : mins + 1'b1;
            end
        end else if (adv_tick) begin
            if (sec == SEC_LAST) begin
                sec <= '0;
                if (mins == MIN_LAST) begin
                    mins <= '0;
                    hr   <= hr_step(hr);
                end else begin
                    mins <= mins + 1'b1;
                end
            end else begin
                sec <= sec + 1'b1;
            end
        end
    end

endmodule

// File: rtl/autoclk_setfsm.sv
module autoclk_setfsm
    import autoclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       sw_hr,
    input  logic       sw_min,
    input  logic       ign_on,
    input  logic       data_lvl,
    output clk_state_e state,
    output logic       all_seg,
    output logic       inc_hr,
    output logic       inc_min,
    output logic       adv_tick,
    output logic       restart,
    output logic       fmt24
);

    clk_state_e nxt;
    logic set_hr_lvl, set_min_lvl;
    logic prev_hr, prev_min;

    assign set_hr_lvl  = ign_on && sw_hr && !sw_min;
    assign set_min_lvl = ign_on && sw_min && !sw_hr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:     if (ign_on && sw_hr && sw_min) nxt = ST_TEST;
            ST_TEST:    if (!sw_hr && !sw_min)         nxt = ST_RESTART;
            ST_RESTART: nxt = ST_RUN;
            default:    nxt = ST_RUN;
        endcase
    end

    // Outputs per state
    always_comb begin
        all_seg  = 1'b0;
        inc_hr   = 1'b0;
        inc_min  = 1'b0;
        adv_tick = tick;
        restart  = 1'b0;
        unique case (state)
            ST_RUN: begin
                inc_hr   = set_hr_lvl  && (!prev_hr  || tick);
                inc_min  = set_min_lvl && (!prev_min || tick);
                adv_tick = tick && !set_hr_lvl && !set_min_lvl;
            end
            ST_TEST: begin
                all_seg = 1'b1;
            end
            ST_RESTART: begin
                restart = data_lvl;
            end
            default: begin
                adv_tick = 1'b0;
            end
        endcase
    end

    // Press history and format flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_hr  <= 1'b0;
            prev_min <= 1'b0;
            fmt24    <= 1'b0;
        end else begin
            prev_hr  <= set_hr_lvl;
            prev_min <= set_min_lvl;
            if (state == ST_RESTART) begin
                fmt24 <= !fmt24;
            end
        end
    end

endmodule

// File: rtl/autoclk_disp.sv
module autoclk_disp #(
    parameter int MIN_N = 60,
    parameter int HR_N  = 24,
    localparam int MW = $clog2(MIN_N),
    localparam int HW = $clog2(HR_N)
) (
    input  logic [HW-1:0] hr,
    input  logic [MW-1:0] mins,
    input  logic          fmt24,
    output logic [3:0]    hr_tens,
    output logic [3:0]    hr_ones,
    output logic [3:0]    min_tens,
    output logic [3:0]    min_ones,
    output logic          am,
    output logic          pm
);

    localparam logic [HW-1:0] HALF = HW'(HR_N / 2);

    logic [HW-1:0] h_mod;
    logic [HW-1:0] h_show;
    logic          after_noon;

    always_comb begin
        after_noon = (hr >= HALF);
        h_mod      = after_noon ? hr - HALF : hr;
        if (fmt24) begin
            h_show = hr;
        end else begin
            h_show = (h_mod == '0) ? HALF : h_mod;
        end
        hr_tens  = 4'(h_show / HW'(10));
        hr_ones  = 4'(h_show % HW'(10));
        min_tens = 4'(mins / MW'(10));
        min_ones = 4'(mins % MW'(10));
        am       = !fmt24 && !after_noon;
        pm       = !fmt24 && after_noon;
    end

endmodule

// File: rtl/autoclk_ctrl.sv
module autoclk_ctrl
    import autoclk_pkg::*;
#(
    parameter int SEC_N    = 60,
    parameter int MIN_N    = 60,
    parameter int HR_N     = 24,
    parameter int START_HR = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       sw_hr,
    input  logic       sw_min,
    input  logic       ign_on,
    input  logic       data_lvl,
    output logic [3:0] hr_tens,
    output logic [3:0] hr_ones,
    output logic [3:0] min_tens,
    output logic [3:0] min_ones,
    output logic       am,
    output logic       pm,
    output logic       fmt24,
    output logic       all_seg
);

    localparam int MW = $clog2(MIN_N);
    localparam int HW = $clog2(HR_N);

    clk_state_e    st;
    logic          inc_hr, inc_min, adv_tick, restart;
    logic [HW-1:0] hr;
    logic [MW-1:0] mins;

    autoclk_setfsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .sw_hr    (sw_hr),
        .sw_min   (sw_min),
        .ign_on   (ign_on),
        .data_lvl (data_lvl),
        .state    (st),
        .all_seg  (all_seg),
        .inc_hr   (inc_hr),
        .inc_min  (inc_min),
        .adv_tick (adv_tick),
        .restart  (restart),
        .fmt24    (fmt24)
    );

    autoclk_time #(
        .SEC_N    (SEC_N),
        .MIN_N    (MIN_N),
        .HR_N     (HR_N),
        .START_HR (START_HR)
    ) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .inc_hr   (inc_hr),
        .inc_min  (inc_min),
        .adv_tick (adv_tick),
        .hr       (hr),
        .mins     (mins)
    );

    autoclk_disp #(
        .MIN_N (MIN_N),
        .HR_N  (HR_N)
    ) u_disp (
        .hr       (hr),
        .mins     (mins),
        .fmt24    (fmt24),
        .hr_tens  (hr_tens),
        .hr_ones  (hr_ones),
        .min_tens (min_tens),
        .min_ones (min_ones),
        .am       (am),
        .pm       (pm)
    );

endmodule

// File: rtl/autoclk_ctrl_chk.sv
module autoclk_ctrl_chk
    import autoclk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       sw_hr,
    input logic       sw_min,
    input logic       ign_on,
    input logic [3:0] hr_tens,
    input logic [3:0] hr_ones,
    input logic [3:0] min_tens,
    input logic [3:0] min_ones,
    input logic       am,
    input logic       pm,
    input logic       fmt24,
    input logic       all_seg,
    input clk_state_e st
);

    logic [7:0] hval;
    assign hval = 8'(hr_tens) * 8'd10 + 8'(hr_ones);

    a_r2_ind_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(am && pm));

    a_r2_fmt24_no_ind: assert property (@(posedge clk) disable iff (!rst_n)
        fmt24 |-> (!am && !pm));

    a_r2_hr12_range: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt24 |-> (hval >= 8'd1 && hval <= 8'd12));

    a_r3_min_digits: assert property (@(posedge clk) disable iff (!rst_n)
        (min_tens <= 4'd5) && (min_ones <= 4'd9));

    a_r6_no_ign_still: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !ign_on && !tick_1hz)
        |=> $stable({hr_tens, hr_ones, min_tens, min_ones, am, pm}));

    a_r7_test_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && ign_on && sw_hr && sw_min) |=> all_seg);

    a_r7_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (all_seg && (sw_hr || sw_min)) |=> all_seg);

    a_r8_fmt_flip: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(all_seg) |=> (fmt24 != $past(fmt24)));

    a_r10_no_test_wo_ign: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !ign_on && sw_hr && sw_min) |=> !all_seg);

endmodule

bind autoclk_ctrl autoclk_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .sw_hr    (sw_hr),
    .sw_min   (sw_min),
    .ign_on   (ign_on),
    .hr_tens  (hr_tens),
    .hr_ones  (hr_ones),
    .min_tens (min_tens),
    .min_ones (min_ones),
    .am       (am),
    .pm       (pm),
    .fmt24    (fmt24),
    .all_seg  (all_seg),
    .st       (st)
);

// File: tb/autoclk_ctrl_tb.sv
module autoclk_ctrl_tb;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1hz = 1'b0, sw_hr = 1'b0, sw_min = 1'b0, ign_on = 1'b0, data_lvl = 1'b1;
    logic [3:0] hr_tens, hr_ones, min_tens, min_ones;
    logic am, pm, fmt24, all_seg;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model of the requirements
    int m_hr, m_min, m_sec, m_st;
    bit m_fmt, m_phr, m_pmin;

    always #(CLK_P/2) clk = ~clk;

    autoclk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .sw_hr(sw_hr),
        .sw_min(sw_min), .ign_on(ign_on), .data_lvl(data_lvl),
        .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens),
        .min_ones(min_ones), .am(am), .pm(pm), .fmt24(fmt24), .all_seg(all_seg)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int shown_hour();
        int h;
        if (m_fmt) return m_hr;
        h = m_hr % 12;
        return (h == 0) ? 12 : h;
    endfunction

    function automatic int act_code();
        return hr_tens * 10000 + hr_ones * 1000 + min_tens * 100 + min_ones * 10
               + am * 2 + pm;
    endfunction

    function automatic int exp_code();
        int h;
        h = shown_hour();
        return (h / 10) * 10000 + (h % 10) * 1000 + (m_min / 10) * 100
               + (m_min % 10) * 10 + ((!m_fmt && m_hr < 12) ? 2 : 0)
               + ((!m_fmt && m_hr >= 12) ? 1 : 0);
    endfunction

    task automatic model_reset();
        m_hr = 1; m_min = 0; m_sec = 0; m_st = 0;
        m_fmt = 0; m_phr = 0; m_pmin = 0;
    endtask

    task automatic model_step();
        bit sh, sm, ih, im, adv, rs;
        int nst;
        sh = ign_on && sw_hr && !sw_min;
        sm = ign_on && sw_min && !sw_hr;
        ih = 0; im = 0; rs = 0; adv = tick_1hz; nst = m_st;
        if (m_st == 0) begin
            if (ign_on && sw_hr && sw_min) nst = 1;
            ih = sh && (!m_phr || tick_1hz);
            im = sm && (!m_pmin || tick_1hz);
            adv = tick_1hz && !sh && !sm;
        end else if (m_st == 1) begin
            if (!sw_hr && !sw_min) nst = 2;
        end else begin
            nst = 0;
            rs = data_lvl;
            m_fmt = !m_fmt;
        end
        if (rs) begin
            m_hr = 1; m_min = 0; m_sec = 0;
        end else if (ih || im) begin
            m_sec = 0;
            if (ih) m_hr = (m_hr + 1) % 24;
            if (im) m_min = (m_min + 1) % 60;
        end else if (adv) begin
            if (m_sec == 59) begin
                m_sec = 0;
                if (m_min == 59) begin
                    m_min = 0;
                    m_hr = (m_hr + 1) % 24;
                end else begin
                    m_min++;
                end
            end else begin
                m_sec++;
            end
        end
        m_phr = sh; m_pmin = sm; m_st = nst;
    endtask

    // One clock: step the model on the current inputs, then compare
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(act_code() == exp_code(), "R2 time/indicators", act_code(), exp_code());
        chk(fmt24 == m_fmt, "R8 format", fmt24, m_fmt);
        chk(all_seg == (m_st == 1), "R7 all_seg", all_seg, (m_st == 1));
    endtask

    task automatic expect_time(input string tag, input int hhmm, input bit e_am, input bit e_pm);
        int a;
        a = hr_tens * 1000 + hr_ones * 100 + min_tens * 10 + min_ones;
        chk(a == hhmm && am == e_am && pm == e_pm, tag, a * 10 + am * 2 + pm,
            hhmm * 10 + e_am * 2 + e_pm);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20417));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_time("R1 reset time", 100, 1, 0);
        chk(fmt24 == 0 && all_seg == 0, "R1 flags", {fmt24, all_seg}, 0);

        // R3 sixty ticks make one minute
        tick_1hz = 1;
        repeat (60) cyc();
        tick_1hz = 0;
        expect_time("R3 minute carry", 101, 1, 0);

        // R4 press then tick-rate repeat
        ign_on = 1; sw_hr = 1;
        cyc();
        expect_time("R4 first press", 201, 1, 0);
        tick_1hz = 1;
        repeat (3) cyc();
        tick_1hz = 0; sw_hr = 0;
        cyc();
        expect_time("R4 repeat", 501, 1, 0);

        // R2 step through noon
        sw_hr = 1;
        cyc();
        tick_1hz = 1;
        repeat (6) cyc();
        tick_1hz = 0; sw_hr = 0;
        cyc();
        expect_time("R2 noon PM", 1201, 0, 1);

        // R5 minute wrap without hour carry
        sw_min = 1;
        cyc();
        tick_1hz = 1;
        repeat (58) cyc();
        tick_1hz = 0; sw_min = 0;
        cyc();
        expect_time("R5 minute wrap", 1200, 0, 1);

        // R6 switches ignored without ignition
        ign_on = 0; sw_hr = 1;
        repeat (4) cyc();
        expect_time("R6 hour ignored", 1200, 0, 1);
        sw_hr = 0; sw_min = 1;
        repeat (4) cyc();
        expect_time("R6 minute ignored", 1200, 0, 1);

        // R10 both switches, no ignition
        sw_hr = 1; sw_min = 1;
        repeat (3) cyc();
        chk(all_seg == 0, "R10 no test state", all_seg, 0);
        expect_time("R10 time kept", 1200, 0, 1);
        sw_hr = 0; sw_min = 0;
        cyc();

        // R7 enter test state; R9 exit with DATA low keeps time
        ign_on = 1; sw_hr = 1; sw_min = 1; data_lvl = 0;
        cyc();
        chk(all_seg == 1, "R7 test entered", all_seg, 1);
        sw_hr = 0;
        repeat (2) cyc();
        chk(all_seg == 1, "R7 held by one switch", all_seg, 1);
        sw_min = 0;
        cyc();
        chk(all_seg == 0, "R7 released", all_seg, 0);
        cyc();
        chk(fmt24 == 1, "R8 format toggled", fmt24, 1);
        expect_time("R9 time kept 24h", 1200, 0, 0);

        // R8 exit with DATA high resets time
        data_lvl = 1; sw_hr = 1; sw_min = 1;
        cyc();
        sw_hr = 0; sw_min = 0;
        cyc();
        cyc();
        chk(fmt24 == 0, "R8 format back", fmt24, 0);
        expect_time("R8 time reset", 100, 1, 0);

        // Random mix of ticks, switches, ignition and DATA
        for (int i = 0; i < 6000; i++) begin
            tick_1hz = ($urandom % 3 == 0);
            if ($urandom % 12 == 0) sw_hr = $urandom % 2;
            if ($urandom % 12 == 0) sw_min = $urandom % 2;
            if ($urandom % 40 == 0) ign_on = !ign_on;
            if ($urandom % 8 == 0) data_lvl = $urandom % 2;
            cyc();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule